// File: doc/BRIEF.md
# Output-Stationary 2x2 Systolic Convolver

This block convolves a 4x4 image of unsigned 8-bit pixels with a 3x3 kernel of unsigned 8-bit weights. The result is the 2x2 map of valid-position sums. The work is done on a 2x2 grid of multiply-accumulate cells, and each cell keeps the partial sum for one output position in place for the whole run. Pixel streams enter the grid from the left and move one cell to the right per clock. Weight streams enter from the top and move one cell down per clock. Row r and column c are skewed by r and c cycles respectively, so the two operands that belong together meet in the correct cell.

With only four cells serving four outputs, the right-hand column cannot share a cycle with the left-hand one. The feeder therefore splits each stream into one phase per output column. It drives the weights of a column only during that column's phase and sends zeros at all other times. A cell therefore never adds a product that belongs to its neighbour's window. The stream is 18 slots long, and the skew adds two more, so a run takes 20 cycles.

Software loads the pixels and weights through a single write port. It then pulses start, waits for done, and reads the four sums through an address-selected result port.

Top module: `sa_conv2x2`

## Requirements
- R1: With ld_en high and busy low, ld_wsel=0 writes ld_data to pixel (row, col) at ld_addr = row*4+col. With ld_wsel=1, ld_data goes to weight (row, col) at ld_addr = row*3+col. Weight writes to addresses 9 to 15 change nothing.
- R2: After done, rd_addr = r*2+c returns out[r][c] = sum over i,j in 0..2 of pixel[r+i][c+j]*weight[i][j], computed unsigned.
- R3: Sums up to the largest possible value, 9*255*255 = 585225, come back exact in the 20-bit result with no wraparound.
- R4: An accepted start clears all four sums before accumulating. Running again on unchanged data returns the same values, not twice those values.
- R5: busy is high in the cycle after the clock edge that samples an accepted start. done rises, and busy falls, exactly 20 clock edges after that sampling edge.
- R6: done stays high until the next accepted start, and busy and done are never high together.
- R7: A start pulse while busy is high is ignored: the run keeps its timing and results.
- R8: Write requests while busy is high are ignored: the stored pixels and weights, and so the results, stay unchanged.
- R9: After reset, busy and done are low and all four results read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write request for the pixel or weight store |
| ld_wsel | input | 1 | 0 selects the pixel store, 1 selects the weight store |
| ld_addr | input | 4 | Flat element address for the write |
| ld_data | input | 8 | Unsigned value to write |
| start | input | 1 | Begin a convolution when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid, held until next start |
| rd_addr | input | 2 | Result select, r*2+c |
| rd_data | output | 20 | Selected unsigned sum |

## Verification
The assertions take the skewed streams at face value. Each cell's forwarded operand is assumed to equal what entered it one cycle earlier, and a column's weight is assumed to be non-zero only inside that column's phase window. The monotonic-sum check also assumes that operands cannot be negative, which holds because every value is unsigned. The stimulus keeps to these conditions: it writes only in-range pixel addresses, it changes the stores or pulses start during a run only in the tests aimed at R7 and R8, and it lets each run reach done before reading results.

// File: rtl/sa_conv_pkg.sv
package sa_conv_pkg;

  // Phase of a stream slot: which output column it serves.
  function automatic int feed_phase(input int slot, input int kn);
    return slot / (kn * kn);
  endfunction

  // Kernel tap (flat row*kn+col) carried by a stream slot.
  function automatic int feed_tap(input int slot, input int kn);
    return slot % (kn * kn);
  endfunction

  // Flat pixel index that row stream 'row' carries in slot 'slot'.
  function automatic int feed_pixel_idx(input int row, input int slot,
                                        input int kn, input int imgn);
    int tap;
    tap = feed_tap(slot, kn);
    return (row + tap / kn) * imgn + feed_phase(slot, kn) + tap % kn;
  endfunction

endpackage

// File: rtl/sa_feeder.sv
module sa_feeder
  import sa_conv_pkg::*;
#(
  parameter int IMG_N = 4,
  parameter int K_N   = 3,
  parameter int DW    = 8,
  parameter int CNT_W = 5,
  parameter int LD_AW = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ld_en,
  input  logic                              ld_wsel,
  input  logic [LD_AW-1:0]                  ld_addr,
  input  logic [DW-1:0]                     ld_data,
  input  logic                              busy,
  input  logic [CNT_W-1:0]                  tick,
  output logic [IMG_N-K_N:0][DW-1:0]        row_feed,
  output logic [IMG_N-K_N:0][DW-1:0]        col_feed
);
  localparam int OUT_N      = IMG_N - K_N + 1;
  localparam int TAPS       = K_N * K_N;
  localparam int PIXELS     = IMG_N * IMG_N;
  localparam int STREAM_LEN = OUT_N * TAPS;
  localparam int PIX_AW     = $clog2(PIXELS);
  localparam int TAP_AW     = $clog2(TAPS);

  logic [PIXELS-1:0][DW-1:0] pix_q;
  logic [TAPS-1:0][DW-1:0]   wgt_q;

  wire wr_ok = ld_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      wgt_q <= '0;
    end else if (wr_ok) begin
      for (int e = 0; e < PIXELS; e++)
        if (!ld_wsel && int'(ld_addr) == e) pix_q[e] <= ld_data;
      for (int e = 0; e < TAPS; e++)
        if (ld_wsel && int'(ld_addr) == e) wgt_q[e] <= ld_data;
    end
  end

  // Row streams: pixels of every column phase, skewed by row.
  always_comb begin
    int slot;
    row_feed = '0;
    for (int r = 0; r < OUT_N; r++) begin
      slot = int'(tick) - r;
      if (busy && slot >= 0 && slot < STREAM_LEN)
        row_feed[r] = pix_q[PIX_AW'(feed_pixel_idx(r, slot, K_N, IMG_N))];
    end
  end

  // Column streams: weights only inside the column's own phase, zero elsewhere.
  always_comb begin
    int slot;
    col_feed = '0;
    for (int c = 0; c < OUT_N; c++) begin
      slot = int'(tick) - c;
      if (busy && slot >= 0 && slot < STREAM_LEN && feed_phase(slot, K_N) == c)
        col_feed[c] = wgt_q[TAP_AW'(feed_tap(slot, K_N))];
    end
  end

  a_r8_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ld_en |=> $stable(pix_q) && $stable(wgt_q));

endmodule

// File: rtl/sa_pe.sv
module sa_pe #(
  parameter int DW    = 8,
  parameter int ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic [DW-1:0]    a_in,
  input  logic [DW-1:0]    b_in,
  output logic [DW-1:0]    a_out,
  output logic [DW-1:0]    b_out,
  output logic [ACC_W-1:0] acc
);
  logic [2*DW-1:0] prod;

  always_comb prod = {{DW{1'b0}}, a_in} * {{DW{1'b0}}, b_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_out <= '0;
      b_out <= '0;
      acc   <= '0;
    end else if (clear) begin
      a_out <= '0;
      b_out <= '0;
      acc   <= '0;
    end else if (en) begin
      a_out <= a_in;
      b_out <= b_in;
      acc   <= acc + {{(ACC_W-2*DW){1'b0}}, prod};
    end
  end

  a_r3_acc_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clear |=> acc >= $past(acc));

endmodule

// File: rtl/sa_conv2x2.sv
module sa_conv2x2 #(
  parameter int IMG_N = 4,
  parameter int K_N   = 3,
  parameter int DW    = 8,
  parameter int ACC_W = 20
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  ld_en,
  input  logic                                  ld_wsel,
  input  logic [$clog2(IMG_N*IMG_N)-1:0]        ld_addr,
  input  logic [DW-1:0]                         ld_data,
  input  logic                                  start,
  output logic                                  busy,
  output logic                                  done,
  input  logic [$clog2((IMG_N-K_N+1)**2)-1:0]   rd_addr,
  output logic [ACC_W-1:0]                      rd_data
);
  localparam int OUT_N      = IMG_N - K_N + 1;
  localparam int TAPS       = K_N * K_N;
  localparam int STREAM_LEN = OUT_N * TAPS;
  localparam int RUN_CYCLES = STREAM_LEN + 2 * (OUT_N - 1);
  localparam int CNT_W      = $clog2(RUN_CYCLES + 1);
  localparam int LD_AW      = $clog2(IMG_N * IMG_N);

  logic             run_q, done_q;
  logic [CNT_W-1:0] tick_q;

  wire launch    = start && !run_q;
  wire last_tick = run_q && (tick_q == CNT_W'(RUN_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      tick_q <= '0;
    end else if (launch) begin
      run_q  <= 1'b1;
      done_q <= 1'b0;
      tick_q <= '0;
    end else if (run_q) begin
      tick_q <= tick_q + CNT_W'(1);
      if (last_tick) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy = run_q;
  assign done = done_q;

  logic [OUT_N-1:0][DW-1:0] row_feed, col_feed;

  sa_feeder #(
    .IMG_N(IMG_N), .K_N(K_N), .DW(DW), .CNT_W(CNT_W), .LD_AW(LD_AW)
  ) feeder_i (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_wsel(ld_wsel), .ld_addr(ld_addr), .ld_data(ld_data),
    .busy(run_q), .tick(tick_q),
    .row_feed(row_feed), .col_feed(col_feed)
  );

  logic [OUT_N-1:0][OUT_N-1:0][DW-1:0]    h_link, v_link;
  logic [OUT_N*OUT_N-1:0][ACC_W-1:0]      acc_flat;

  for (genvar r = 0; r < OUT_N; r++) begin : g_r
    for (genvar c = 0; c < OUT_N; c++) begin : g_c
      logic [DW-1:0] a_src, b_src;
      if (c == 0) begin : g_left
        assign a_src = row_feed[r];
      end else begin : g_inner_h
        assign a_src = h_link[r][c-1];
      end
      if (r == 0) begin : g_top
        assign b_src = col_feed[c];
      end else begin : g_inner_v
        assign b_src = v_link[r-1][c];
      end
      sa_pe #(.DW(DW), .ACC_W(ACC_W)) pe_i (
        .clk(clk), .rst_n(rst_n), .clear(launch), .en(run_q),
        .a_in(a_src), .b_in(b_src),
        .a_out(h_link[r][c]), .b_out(v_link[r][c]),
        .acc(acc_flat[r*OUT_N+c])
      );
    end
  end

  assign rd_data = acc_flat[rd_addr];

  // Assertions
  for (genvar k = 0; k < OUT_N; k++) begin : g_chk
    a_r2_row_pass: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> h_link[k][0] == $past(row_feed[k]));
    a_r2_col_pass: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> v_link[0][k] == $past(col_feed[k]));
    a_r2_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
      col_feed[k] != '0 |-> (int'(tick_q) >= k * (TAPS + 1)) &&
                            (int'(tick_q) <  k * (TAPS + 1) + TAPS));
  end

  a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_q && done_q));
  a_r5_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(tick_q) == CNT_W'(RUN_CYCLES - 1));
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && start && !last_tick |=> run_q && tick_q == $past(tick_q) + CNT_W'(1));

endmodule

// File: tb/sa_conv2x2_tb.sv
`timescale 1ns/1ps
module sa_conv2x2_tb_top;
  localparam int LAT = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0, ld_wsel = 1'b0, start = 1'b0;
  logic [3:0]  ld_addr = '0;
  logic [7:0]  ld_data = '0;
  logic [1:0]  rd_addr = '0;
  logic        busy, done;
  logic [19:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  sa_conv2x2 dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_wsel(ld_wsel),
    .ld_addr(ld_addr), .ld_data(ld_data), .start(start),
    .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  localparam logic [127:0] IMG_V [4] = '{
    128'h0F0E0D0C0B0A09080706050403020100,
    128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF,
    128'h00112233445566778899AABBCCDDEEFF,
    128'h80402010080402018040201008040201
  };
  localparam logic [71:0] WGT_V [4] = '{
    72'h090807060504030201,
    72'hFFFFFFFFFFFFFFFFFF,
    72'h010000000000000000,
    72'h7F00FF0011002200AA
  };

  function automatic int unsigned ref_out(logic [127:0] img, logic [71:0] w, int r, int c);
    int unsigned s = 0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        s += img[((r + i) * 4 + c + j) * 8 +: 8] * w[(i * 3 + j) * 8 +: 8];
    return s;
  endfunction

  task automatic chk(string req, int unsigned act, int unsigned exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write(logic sel, int addr, logic [7:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_wsel = sel; ld_addr = 4'(addr); ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load(logic [127:0] img, logic [71:0] w);
    for (int n = 0; n < 16; n++) write(1'b0, n, img[n*8 +: 8]);
    for (int n = 0; n < 9; n++)  write(1'b1, n, w[n*8 +: 8]);
  endtask

  // Runs one convolution; optional disturbances mid-run. Returns edges to done.
  task automatic run(input bit poke_start, input bit poke_load, output int lat);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    chk("R5 busy after start", busy, 1);
    while (!done && lat < 100) begin
      if (poke_start && lat == 5) start = 1'b1;
      if (poke_load && lat == 7) begin
        ld_en = 1'b1; ld_wsel = 1'b0; ld_addr = 4'd5; ld_data = 8'hAA;
      end
      @(negedge clk);
      start = 1'b0;
      ld_en = 1'b0;
      lat++;
      if (lat == LAT - 1) chk("R5 done not early", done, 0);
    end
    chk("R5 run latency", lat, LAT);
    chk("R6 busy low at done", busy, 0);
  endtask

  task automatic check_results(string req, logic [127:0] img, logic [71:0] w);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      chk(req, rd_data, ref_out(img, w, a / 2, a % 2));
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 busy", busy, 0);
    chk("R9 done", done, 0);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1;
      chk("R9 zero result", rd_data, 0);
    end
    rst_n = 1'b1;

    // Vector table: R1 load, R2 convolution, R3 max sum, R5 timing
    for (int v = 0; v < 4; v++) begin
      load(IMG_V[v], WGT_V[v]);
      run(1'b0, 1'b0, lat);
      check_results("R2 R1 R3 vector result", IMG_V[v], WGT_V[v]);
    end

    // R6: done holds until next start
    repeat (5) @(negedge clk);
    chk("R6 done held", done, 1);

    // R4: rerun on same data gives same sums, not doubled
    run(1'b0, 1'b0, lat);
    check_results("R4 rerun cleared", IMG_V[3], WGT_V[3]);

    // R1: weight writes to addresses 9..15 ignored
    load(IMG_V[0], WGT_V[0]);
    write(1'b1, 12, 8'h55);
    write(1'b1, 9, 8'h33);
    write(1'b1, 15, 8'h77);
    run(1'b0, 1'b0, lat);
    check_results("R1 high weight addr ignored", IMG_V[0], WGT_V[0]);

    // R7: start while busy ignored
    run(1'b1, 1'b0, lat);
    check_results("R7 start while busy", IMG_V[0], WGT_V[0]);

    // R8: load while busy ignored (result and subsequent rerun unaffected)
    run(1'b0, 1'b1, lat);
    check_results("R8 load while busy", IMG_V[0], WGT_V[0]);
    run(1'b0, 1'b0, lat);
    check_results("R8 store unchanged", IMG_V[0], WGT_V[0]);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule